// File: doc/BRIEF.md
# Descriptor Free-Queue Prefetch Engine

This block keeps a small on-chip store of free-buffer descriptors ready for a receive DMA engine, so that the DMA never waits on host memory when it needs a fresh buffer. The descriptors live in circular rings in host memory. The host advances a write pointer for each ring as it posts descriptors. The engine tracks its own read pointer for each ring and refills the local store with burst reads. It never reads beyond what the host has posted.

The store holds up to 16 descriptors of 64 bits each. The engine runs in one of two modes, chosen by the ring address configuration. In single mode there is one large-buffer ring, and all 16 entries serve it. In dual mode the store is split into two 8-entry halves, one for a large-buffer ring and one for a small-buffer ring. A refill is triggered only when a half or the whole store drains to its low watermark. Four sticky status flags record completed bursts and empty-ring conditions, and an interrupt line is raised from the flags that are unmasked.

The controller has three named states. `FQ_IDLE` evaluates the watermarks and flags empty rings, and it takes the launch transition to `FQ_REQ` when a ring can be served. `FQ_REQ` holds the burst request and takes the accept transition to `FQ_RECV` on `rd_req_ready`. `FQ_RECV` stores one response beat per `rsp_valid`, and on the last beat it takes the finish transition back to `FQ_IDLE`.

Top module: `desc_prefetch_engine`

## Requirements
- R1: Mode selection. The engine is in single mode when `sm_ring_base == ring_last`, and its large store then holds up to 16 descriptors while the small store holds none. Any other configuration selects dual mode, with 8 entries for each class. The large ring runs from `lg_ring_base` to `lg_ring_last`. The small ring runs from `sm_ring_base` to `ring_last`.
- R2: When `prefetch_en` is high and the engine is idle, a refill of a store starts only if that store's occupancy is at or below its low watermark. The watermark is 4 in single mode and 2 for each half in dual mode. No request is raised otherwise.
- R3: A burst request carries the ring's read pointer as `rd_req_addr`, in descriptor index units. Its `rd_req_len` is the smallest of three values: the free room in the store, the number of descriptors the host has posted, and the distance from the read pointer to the ring's last entry inclusive.
- R4: When a store has reached its watermark but its ring is empty (read pointer equals host write pointer), no request is made and the read pointer is unchanged. The error flag is set: `status[2]` for the large ring, `status[3]` for the small ring.
- R5: After the last beat of a burst, that ring's read pointer advances by the burst length. It returns to the ring base when the burst ended on the ring's last entry.
- R6: The done flags are `status[0]` for a large burst and `status[1]` for a small burst. All four status bits are sticky and are cleared by writing 1 to the matching `status_clr` bit. A set in the same cycle as a clear wins. All bits are 0 after reset.
- R7: `irq` is high exactly when some status bit is 1 and its `irq_mask` bit is 1.
- R8: Only one burst is in flight at a time. When both halves need service in the same idle cycle, the large ring is served first. `rd_req_small` is 0 for a large burst and 1 for a small burst.
- R9: Descriptors are presented on the head outputs in the order in which they arrived. A pop in the same cycle as a response beat for the same store loses no entry.
- R10: A pop on an empty store is ignored. `*_head_valid` stays 0 and no state changes.
- R11: While `rd_req_valid` is high and `rd_req_ready` is low, the request stays asserted with unchanged address, length and class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prefetch_en | input | 1 | Enables watermark-driven refills |
| lg_ring_base | input | ADDR_W | First entry of the large ring |
| lg_ring_last | input | ADDR_W | Last entry of the large ring |
| sm_ring_base | input | ADDR_W | First entry of the small ring; equal to ring_last selects single mode |
| ring_last | input | ADDR_W | Last entry of the small ring |
| lg_host_wr | input | ADDR_W | Host write pointer, large ring |
| sm_host_wr | input | ADDR_W | Host write pointer, small ring |
| lg_rd_ptr | output | ADDR_W | Engine read pointer, large ring |
| sm_rd_ptr | output | ADDR_W | Engine read pointer, small ring |
| rd_req_valid | output | 1 | Burst read request pending |
| rd_req_ready | input | 1 | Memory side accepts the request |
| rd_req_addr | output | ADDR_W | First descriptor index of the burst |
| rd_req_len | output | CW | Descriptors in the burst |
| rd_req_small | output | 1 | 1 = small ring burst |
| rsp_valid | input | 1 | One descriptor of the burst returned |
| rsp_data | input | DESC_W | Returned descriptor |
| lg_pop | input | 1 | DMA takes the large head descriptor |
| lg_head_valid | output | 1 | Large store not empty |
| lg_head_data | output | DESC_W | Oldest large descriptor |
| sm_pop | input | 1 | DMA takes the small head descriptor |
| sm_head_valid | output | 1 | Small store not empty |
| sm_head_data | output | DESC_W | Oldest small descriptor |
| status | output | 4 | Sticky flags: large done, small done, large error, small error |
| status_clr | input | 4 | Write-1-to-clear strobe per flag |
| irq_mask | input | 4 | Interrupt enable per flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets several corner cases. One is the store sitting exactly at its watermark: a design with an off-by-one compare would refill one descriptor early or late. Another is a ring holding fewer descriptors than the free room, or a read pointer near the ring end: a design that clips wrongly would read descriptors the host never posted, or run past the ring end. A third is an empty ring at trigger time: a design that got this wrong would issue a zero-length burst or move its pointer instead of raising the error flag. The bench also drives a clear that coincides with a new error, and pops that coincide with response beats or hit an empty store. A wrong design there would lose the flag, drop or duplicate a descriptor, or corrupt the head order.

// File: rtl/fq_pkg.sv
package fq_pkg;
    typedef enum logic [1:0] {
        FQ_IDLE = 2'd0,
        FQ_REQ  = 2'd1,
        FQ_RECV = 2'd2
    } fq_state_e;

    localparam int ST_LG_DONE = 0;
    localparam int ST_SM_DONE = 1;
    localparam int ST_LG_ERR  = 2;
    localparam int ST_SM_ERR  = 3;
    localparam int ST_W       = 4;
endpackage

// File: rtl/ring_span.sv
module ring_span #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] last,
    input  logic [ADDR_W-1:0] host_wr,
    input  logic              adv,
    input  logic [ADDR_W-1:0] adv_len,
    output logic [ADDR_W-1:0] rd,
    output logic [ADDR_W-1:0] avail,
    output logic [ADDR_W-1:0] to_end
);
    logic [ADDR_W-1:0] size;
    logic [ADDR_W-1:0] burst_end;

    assign size      = last - base + 1'b1;
    assign avail     = (host_wr >= rd) ? (host_wr - rd) : (size - (rd - host_wr));
    assign to_end    = last - rd + 1'b1;
    assign burst_end = rd + adv_len - 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd <= base;
        end else if (adv) begin
            rd <= (burst_end == last) ? base : (rd + adv_len);
        end
    end

    // R5: the read pointer never leaves its ring
    assert_ptr_in_ring_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd >= base) && (rd <= last));
endmodule

// File: rtl/desc_split_fifo.sv
module desc_split_fifo #(
    parameter int DEPTH = 16,
    parameter int DW    = 64
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               dual,
    input  logic                               wr_en,
    input  logic                               wr_sel,
    input  logic [DW-1:0]                      wr_data,
    input  logic [1:0]                         pop,
    output logic [1:0][DW-1:0]                 head_data,
    output logic [1:0][$clog2(DEPTH+1)-1:0]    count
);
    localparam int HALF = DEPTH / 2;
    localparam int IW   = $clog2(DEPTH);
    localparam int CW   = $clog2(DEPTH + 1);

    logic [DW-1:0]         mem [DEPTH];
    logic [1:0][CW-1:0]    cap;
    logic [1:0][IW-1:0]    base_slot;
    logic [1:0][IW-1:0]    wr_slot;
    logic [1:0][IW-1:0]    rd_slot;

    assign cap[0]       = dual ? CW'(HALF) : CW'(DEPTH);
    assign cap[1]       = dual ? CW'(HALF) : CW'(0);
    assign base_slot[0] = IW'(0);
    assign base_slot[1] = IW'(HALF);

    for (genvar q = 0; q < 2; q++) begin : g_q
        logic [IW-1:0] head_r;
        logic [CW-1:0] cnt_r;
        logic [CW:0]   tail_sum;
        logic          push, take;

        assign push     = wr_en && (wr_sel == q[0]);
        assign take     = pop[q] && (cnt_r != '0);
        assign tail_sum = (CW+1)'(head_r) + (CW+1)'(cnt_r);
        assign wr_slot[q] = base_slot[q] + ((tail_sum >= (CW+1)'(cap[q]))
                            ? IW'(tail_sum - (CW+1)'(cap[q])) : IW'(tail_sum));
        assign rd_slot[q] = base_slot[q] + head_r;
        assign count[q]   = cnt_r;
        assign head_data[q] = mem[rd_slot[q]];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                head_r <= '0;
                cnt_r  <= '0;
            end else begin
                if (take) begin
                    head_r <= (head_r == IW'(cap[q] - 1'b1)) ? '0 : head_r + 1'b1;
                end
                cnt_r <= cnt_r + CW'(push) - CW'(take);
            end
        end

        // R9: a beat is never written into a full store
        assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
            push |-> (cnt_r < cap[q]));
        // R10: popping an empty store leaves it empty
        assert_empty_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (pop[q] && cnt_r == '0 && !push) |=> (cnt_r == '0));
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_slot[wr_sel]] <= wr_data;
        end
    end

    // R1: the small half stays unused in single mode
    assert_single_no_small_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !dual |-> (count[1] == '0));
endmodule

// File: rtl/desc_prefetch_engine.sv
module desc_prefetch_engine
    import fq_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int DESC_W     = 64,
    parameter int FIFO_DEPTH = 16,
    parameter int WM_DUAL    = 2,
    parameter int WM_SINGLE  = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              prefetch_en,
    input  logic [ADDR_W-1:0]                 lg_ring_base,
    input  logic [ADDR_W-1:0]                 lg_ring_last,
    input  logic [ADDR_W-1:0]                 sm_ring_base,
    input  logic [ADDR_W-1:0]                 ring_last,
    input  logic [ADDR_W-1:0]                 lg_host_wr,
    input  logic [ADDR_W-1:0]                 sm_host_wr,
    output logic [ADDR_W-1:0]                 lg_rd_ptr,
    output logic [ADDR_W-1:0]                 sm_rd_ptr,
    output logic                              rd_req_valid,
    input  logic                              rd_req_ready,
    output logic [ADDR_W-1:0]                 rd_req_addr,
    output logic [$clog2(FIFO_DEPTH+1)-1:0]   rd_req_len,
    output logic                              rd_req_small,
    input  logic                              rsp_valid,
    input  logic [DESC_W-1:0]                 rsp_data,
    input  logic                              lg_pop,
    output logic                              lg_head_valid,
    output logic [DESC_W-1:0]                 lg_head_data,
    input  logic                              sm_pop,
    output logic                              sm_head_valid,
    output logic [DESC_W-1:0]                 sm_head_data,
    output logic [3:0]                        status,
    input  logic [3:0]                        status_clr,
    input  logic [3:0]                        irq_mask,
    output logic                              irq
);
    localparam int CW   = $clog2(FIFO_DEPTH + 1);
    localparam int HALF = FIFO_DEPTH / 2;
    localparam logic [CW-1:0] WM_D = CW'(WM_DUAL);
    localparam logic [CW-1:0] WM_S = CW'(WM_SINGLE);

    fq_state_e state, state_nx;

    logic                     dual;
    logic [1:0][ADDR_W-1:0]   r_base, r_last, r_wr, r_rd, r_avail, r_to_end, need_w, pick_w;
    logic [1:0][CW-1:0]       cap, fcnt, len_pick;
    logic [1:0][DESC_W-1:0]   fhead;
    logic [1:0]               trig, go, adv;
    logic                     pick_small;
    logic                     launch, accept, beat, finish;
    logic                     bl_small;
    logic [ADDR_W-1:0]        bl_addr;
    logic [CW-1:0]            bl_len, left;
    logic [ST_W-1:0]          set_vec;

    assign dual      = (sm_ring_base != ring_last);
    assign r_base[0] = lg_ring_base;
    assign r_base[1] = sm_ring_base;
    assign r_last[0] = lg_ring_last;
    assign r_last[1] = ring_last;
    assign r_wr[0]   = lg_host_wr;
    assign r_wr[1]   = sm_host_wr;
    assign cap[0]    = dual ? CW'(HALF) : CW'(FIFO_DEPTH);
    assign cap[1]    = dual ? CW'(HALF) : CW'(0);

    for (genvar q = 0; q < 2; q++) begin : g_ring
        ring_span #(.ADDR_W(ADDR_W)) u_ring (
            .clk     (clk),
            .rst_n   (rst_n),
            .base    (r_base[q]),
            .last    (r_last[q]),
            .host_wr (r_wr[q]),
            .adv     (adv[q]),
            .adv_len (ADDR_W'(bl_len)),
            .rd      (r_rd[q]),
            .avail   (r_avail[q]),
            .to_end  (r_to_end[q])
        );
        assign adv[q] = finish && (bl_small == q[0]);
    end

    desc_split_fifo #(.DEPTH(FIFO_DEPTH), .DW(DESC_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .dual      (dual),
        .wr_en     (beat),
        .wr_sel    (bl_small),
        .wr_data   (rsp_data),
        .pop       ({sm_pop, lg_pop}),
        .head_data (fhead),
        .count     (fcnt)
    );

    // Burst sizing: free room, posted descriptors, distance to ring end
    always_comb begin
        for (int q = 0; q < 2; q++) begin
            need_w[q] = ADDR_W'(cap[q] - fcnt[q]);
            pick_w[q] = need_w[q];
            if (r_avail[q] < pick_w[q])  pick_w[q] = r_avail[q];
            if (r_to_end[q] < pick_w[q]) pick_w[q] = r_to_end[q];
            len_pick[q] = CW'(pick_w[q]);
        end
    end

    assign trig[0]    = prefetch_en && (fcnt[0] <= (dual ? WM_D : WM_S));
    assign trig[1]    = prefetch_en && dual && (fcnt[1] <= WM_D);
    assign go[0]      = trig[0] && (r_avail[0] != '0);
    assign go[1]      = trig[1] && (r_avail[1] != '0);
    assign pick_small = !go[0] && go[1];

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= FQ_IDLE;
        else        state <= state_nx;
    end

    // Next state and transition strobes
    always_comb begin
        state_nx = state;
        launch   = 1'b0;
        accept   = 1'b0;
        beat     = 1'b0;
        finish   = 1'b0;
        unique case (state)
            FQ_IDLE: if (go[0] || go[1]) begin
                state_nx = FQ_REQ;
                launch   = 1'b1;
            end
            FQ_REQ: if (rd_req_ready) begin
                state_nx = FQ_RECV;
                accept   = 1'b1;
            end
            FQ_RECV: if (rsp_valid) begin
                beat = 1'b1;
                if (left == CW'(1)) begin
                    finish   = 1'b1;
                    state_nx = FQ_IDLE;
                end
            end
            default: state_nx = FQ_IDLE;
        endcase
    end

    // Burst bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bl_small <= 1'b0;
            bl_addr  <= '0;
            bl_len   <= '0;
            left     <= '0;
        end else begin
            if (launch) begin
                bl_small <= pick_small;
                bl_addr  <= r_rd[pick_small];
                bl_len   <= len_pick[pick_small];
            end
            if (accept)    left <= bl_len;
            else if (beat) left <= left - 1'b1;
        end
    end

    // Status flags: sticky, write-1 clear, set wins
    always_comb begin
        set_vec             = '0;
        set_vec[ST_LG_ERR]  = (state == FQ_IDLE) && trig[0] && (r_avail[0] == '0);
        set_vec[ST_SM_ERR]  = (state == FQ_IDLE) && trig[1] && (r_avail[1] == '0);
        set_vec[ST_LG_DONE] = finish && !bl_small;
        set_vec[ST_SM_DONE] = finish && bl_small;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~status_clr) | set_vec;
    end

    // Outputs
    always_comb begin
        rd_req_valid  = (state == FQ_REQ);
        rd_req_addr   = bl_addr;
        rd_req_len    = bl_len;
        rd_req_small  = bl_small;
        lg_rd_ptr     = r_rd[0];
        sm_rd_ptr     = r_rd[1];
        lg_head_valid = (fcnt[0] != '0);
        sm_head_valid = (fcnt[1] != '0);
        lg_head_data  = fhead[0];
        sm_head_data  = fhead[1];
        irq           = |(status & irq_mask);
    end

    // R3: a request never asks for zero or for more than the host posted
    assert_len_clipped_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid |-> (rd_req_len != '0) && (ADDR_W'(rd_req_len) <= r_avail[rd_req_small]));
    // R11: request is held stable until accepted
    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_valid && !rd_req_ready) |=> rd_req_valid && $stable(rd_req_addr)
            && $stable(rd_req_len) && $stable(rd_req_small));
    // R4: raising an error flag leaves the read pointer in place
    assert_err_no_move_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[ST_LG_ERR]) |-> $stable(lg_rd_ptr));
    // R6: a flag only falls when it was written with 1
    assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((~status & $past(status) & ~$past(status_clr)) == 4'b0));
    // R8: small bursts only exist in dual mode
    assert_small_dual_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_valid && rd_req_small) |-> dual);
endmodule

// File: tb/desc_prefetch_engine_bench.sv
module desc_prefetch_engine_bench;
    localparam int AW    = 12;
    localparam int DW    = 64;
    localparam int DEPTH = 16;
    localparam int CW    = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n, prefetch_en;
    logic [AW-1:0] lg_ring_base, lg_ring_last, sm_ring_base, ring_last;
    logic [AW-1:0] lg_host_wr, sm_host_wr, lg_rd_ptr, sm_rd_ptr;
    logic          rd_req_valid, rd_req_ready, rd_req_small;
    logic [AW-1:0] rd_req_addr;
    logic [CW-1:0] rd_req_len;
    logic          rsp_valid;
    logic [DW-1:0] rsp_data;
    logic          lg_pop, lg_head_valid, sm_pop, sm_head_valid;
    logic [DW-1:0] lg_head_data, sm_head_data;
    logic [3:0]    status, status_clr, irq_mask;
    logic          irq;

    desc_prefetch_engine #(.ADDR_W(AW), .DESC_W(DW), .FIFO_DEPTH(DEPTH)) u_desc_prefetch_engine (
        .clk(clk), .rst_n(rst_n), .prefetch_en(prefetch_en),
        .lg_ring_base(lg_ring_base), .lg_ring_last(lg_ring_last),
        .sm_ring_base(sm_ring_base), .ring_last(ring_last),
        .lg_host_wr(lg_host_wr), .sm_host_wr(sm_host_wr),
        .lg_rd_ptr(lg_rd_ptr), .sm_rd_ptr(sm_rd_ptr),
        .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
        .rd_req_addr(rd_req_addr), .rd_req_len(rd_req_len), .rd_req_small(rd_req_small),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .lg_pop(lg_pop), .lg_head_valid(lg_head_valid), .lg_head_data(lg_head_data),
        .sm_pop(sm_pop), .sm_head_valid(sm_head_valid), .sm_head_data(sm_head_data),
        .status(status), .status_clr(status_clr), .irq_mask(irq_mask), .irq(irq)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit chk_on = 1'b0;
    int ready_pct, rsp_pct, lg_pop_pct, sm_pop_pct, post_pct, clr_pct;
    logic [63:0] rsp_seq = 64'hD000_0000_0000_0001;

    // Behavioural reference model
    int          m_state, m_sel, m_addr, m_len, m_left;
    int          m_rd [2];
    logic [3:0]  m_status;
    logic [63:0] mq0 [$];
    logic [63:0] mq1 [$];

    function automatic int ring_avail(int rd, int wr, int b, int l);
        if (wr >= rd) return wr - rd;
        return (l - b + 1) - (rd - wr);
    endfunction

    function automatic int min3(int a, int b, int c);
        int m;
        m = a;
        if (b < m) m = b;
        if (c < m) m = c;
        return m;
    endfunction

    always @(posedge clk) begin : mdl
        bit         dual_m, t0, t1;
        int         cnt0, cnt1, a0, a1, cap0, cap1, nst, lb, ll;
        logic [3:0] ns;
        if (!rst_n) begin
            m_state  = 0;
            m_rd[0]  = int'(lg_ring_base);
            m_rd[1]  = int'(sm_ring_base);
            m_status = 4'h0;
            m_left   = 0;
            mq0.delete();
            mq1.delete();
        end else begin
            dual_m = (sm_ring_base != ring_last);
            cap0   = dual_m ? 8 : 16;
            cap1   = dual_m ? 8 : 0;
            cnt0   = mq0.size();
            cnt1   = mq1.size();
            a0     = ring_avail(m_rd[0], int'(lg_host_wr), int'(lg_ring_base), int'(lg_ring_last));
            a1     = ring_avail(m_rd[1], int'(sm_host_wr), int'(sm_ring_base), int'(ring_last));
            ns     = m_status & ~status_clr;
            nst    = m_state;
            case (m_state)
                0: if (prefetch_en) begin
                    t0 = cnt0 <= (dual_m ? 2 : 4);
                    t1 = dual_m && (cnt1 <= 2);
                    if (t0 && a0 == 0) ns[2] = 1'b1;
                    if (t1 && a1 == 0) ns[3] = 1'b1;
                    if (t0 && a0 > 0) begin
                        m_sel = 0; m_addr = m_rd[0];
                        m_len = min3(cap0 - cnt0, a0, int'(lg_ring_last) - m_rd[0] + 1);
                        nst = 1;
                    end else if (t1 && a1 > 0) begin
                        m_sel = 1; m_addr = m_rd[1];
                        m_len = min3(cap1 - cnt1, a1, int'(ring_last) - m_rd[1] + 1);
                        nst = 1;
                    end
                end
                1: if (rd_req_ready) begin
                    nst = 2;
                    m_left = m_len;
                end
                default: ;
            endcase
            if (lg_pop && cnt0 > 0) void'(mq0.pop_front());
            if (sm_pop && cnt1 > 0) void'(mq1.pop_front());
            if (m_state == 2 && rsp_valid) begin
                if (m_sel == 0) mq0.push_back(rsp_data);
                else            mq1.push_back(rsp_data);
                m_left = m_left - 1;
                if (m_left == 0) begin
                    lb = (m_sel == 0) ? int'(lg_ring_base) : int'(sm_ring_base);
                    ll = (m_sel == 0) ? int'(lg_ring_last) : int'(ring_last);
                    m_rd[m_sel] = (m_rd[m_sel] + m_len - 1 == ll) ? lb : m_rd[m_sel] + m_len;
                    ns[m_sel] = 1'b1;
                    nst = 0;
                end
            end
            m_status = ns;
            m_state  = nst;
        end
    end

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R2", "req_valid", 64'(rd_req_valid), 64'(m_state == 1));
        if (m_state == 1) begin
            chk("R3", "req_addr", 64'(rd_req_addr), 64'(m_addr));
            chk("R3", "req_len", 64'(rd_req_len), 64'(m_len));
            chk("R8", "req_small", 64'(rd_req_small), 64'(m_sel));
        end
        chk("R5", "lg_rd_ptr", 64'(lg_rd_ptr), 64'(m_rd[0]));
        chk("R5", "sm_rd_ptr", 64'(sm_rd_ptr), 64'(m_rd[1]));
        chk("R6", "status", 64'(status), 64'(m_status));
        chk("R7", "irq", 64'(irq), 64'(|(m_status & irq_mask)));
        chk("R10", "lg_head_valid", 64'(lg_head_valid), 64'(mq0.size() != 0));
        chk("R10", "sm_head_valid", 64'(sm_head_valid), 64'(mq1.size() != 0));
        if (mq0.size() != 0) chk("R9", "lg_head_data", lg_head_data, mq0[0]);
        if (mq1.size() != 0) chk("R9", "sm_head_data", sm_head_data, mq1[0]);
    endtask

    task automatic tick();
        int sz;
        @(negedge clk);
        if (chk_on) compare_all();
        rd_req_ready = ($urandom_range(99, 0) < ready_pct);
        rsp_valid    = (m_state == 2) && ($urandom_range(99, 0) < rsp_pct);
        if (rsp_valid) begin
            rsp_data = rsp_seq;
            rsp_seq  = rsp_seq + 64'd1;
        end
        lg_pop     = ($urandom_range(99, 0) < lg_pop_pct);
        sm_pop     = ($urandom_range(99, 0) < sm_pop_pct);
        status_clr = ($urandom_range(99, 0) < clr_pct) ? 4'($urandom_range(15, 0)) : 4'h0;
        sz = int'(lg_ring_last) - int'(lg_ring_base) + 1;
        if ($urandom_range(99, 0) < post_pct &&
            ring_avail(m_rd[0], int'(lg_host_wr), int'(lg_ring_base), int'(lg_ring_last)) < sz - 1)
            lg_host_wr = (lg_host_wr == lg_ring_last) ? lg_ring_base : lg_host_wr + 1'b1;
        sz = int'(ring_last) - int'(sm_ring_base) + 1;
        if (sm_ring_base != ring_last && $urandom_range(99, 0) < post_pct &&
            ring_avail(m_rd[1], int'(sm_host_wr), int'(sm_ring_base), int'(ring_last)) < sz - 1)
            sm_host_wr = (sm_host_wr == ring_last) ? sm_ring_base : sm_host_wr + 1'b1;
    endtask

    task automatic knobs(input int rdy, input int rsp, input int lp, input int sp, input int post, input int clr);
        ready_pct = rdy; rsp_pct = rsp; lg_pop_pct = lp; sm_pop_pct = sp; post_pct = post; clr_pct = clr;
    endtask

    task automatic wait_req();
        for (int i = 0; i < 200 && !rd_req_valid; i++) tick();
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R2 watchdog: act=running exp=finished");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; prefetch_en = 1'b1;
        rd_req_ready = 1'b0; rsp_valid = 1'b0; rsp_data = '0;
        lg_pop = 1'b0; sm_pop = 1'b0; status_clr = 4'h0; irq_mask = 4'b0100;
        knobs(0, 0, 0, 0, 0, 0);
        // Single mode: large ring 0..39
        lg_ring_base = 12'd0;   lg_ring_last = 12'd39;
        sm_ring_base = 12'd100; ring_last    = 12'd100;
        lg_host_wr   = 12'd0;   sm_host_wr   = 12'd100;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R6", "reset status", 64'(status), 64'h0);
        chk("R2", "reset req_valid", 64'(rd_req_valid), 64'h0);
        chk("R10", "reset lg_head_valid", 64'(lg_head_valid), 64'h0);
        rst_n  = 1'b1;
        chk_on = 1'b1;

        tick();
        chk("R4", "lg err flag on empty ring", 64'(status[2]), 64'h1);
        chk("R4", "no request on empty ring", 64'(rd_req_valid), 64'h0);
        chk("R4", "pointer held on empty ring", 64'(lg_rd_ptr), 64'h0);
        chk("R7", "irq from unmasked err", 64'(irq), 64'h1);

        lg_pop_pct = 100;
        tick(); tick();
        chk("R10", "pop on empty store", 64'(lg_head_valid), 64'h0);
        lg_pop_pct = 0;

        status_clr = 4'h4;
        tick();
        chk("R6", "set wins over clear", 64'(status[2]), 64'h1);
        prefetch_en = 1'b0;
        status_clr  = 4'h4;
        tick();
        chk("R6", "write-1 clears flag", 64'(status[2]), 64'h0);
        chk("R7", "irq drops after clear", 64'(irq), 64'h0);

        lg_host_wr  = 12'd30;
        prefetch_en = 1'b1;
        tick();
        chk("R1", "single mode burst fills 16", 64'(rd_req_len), 64'd16);
        chk("R3", "burst starts at read pointer", 64'(rd_req_addr), 64'd0);
        for (int i = 0; i < 4; i++) begin
            tick();
            chk("R11", "request held while not ready", 64'({rd_req_valid, rd_req_len}), 64'({1'b1, 5'd16}));
        end
        knobs(100, 100, 0, 0, 0, 0);
        for (int i = 0; i < 100 && lg_rd_ptr != 12'd16; i++) tick();
        chk("R5", "pointer advanced by burst", 64'(lg_rd_ptr), 64'd16);
        chk("R6", "large done flag", 64'(status[0]), 64'h1);

        irq_mask = 4'b1111;
        knobs(60, 70, 30, 0, 40, 10);
        repeat (3000) tick();

        // Dual mode: large 0..19, small 64..87
        chk_on = 1'b0;
        knobs(100, 100, 0, 0, 0, 0);
        rst_n = 1'b0;
        lg_ring_base = 12'd0;  lg_ring_last = 12'd19;
        sm_ring_base = 12'd64; ring_last    = 12'd87;
        lg_host_wr   = 12'd10; sm_host_wr   = 12'd70;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n  = 1'b1;
        chk_on = 1'b1;
        wait_req();
        chk("R8", "large served first", 64'(rd_req_small), 64'h0);
        chk("R1", "dual mode half holds 8", 64'(rd_req_len), 64'd8);
        for (int i = 0; i < 100 && rd_req_valid; i++) tick();
        for (int i = 0; i < 100 && (m_state != 0); i++) tick();
        wait_req();
        chk("R8", "small burst after large", 64'(rd_req_small), 64'h1);
        chk("R3", "burst clipped to posted", 64'(rd_req_len), 64'd6);

        knobs(60, 70, 30, 30, 35, 10);
        repeat (3000) tick();
        knobs(80, 80, 60, 60, 5, 5);
        repeat (1500) tick();

        finish_run();
    end
endmodule